// File: doc/BRIEF.md
# Transmit Symbol Start and Amplitude Ramp Controller

This block sits in a digital radio transmitter between a word FIFO and the pulse-shaping filter. On each symbol boundary it takes one word from the FIFO. Each word carries an amplitude-request flag and a 3-bit symbol field. The symbol is turned into a constellation index in one of two ways. In the normal path a differential phase accumulator adds the symbol to a running phase. In the bypass path the field is taken as the absolute index.

The block also produces a 10-bit amplitude scale for the output stage. When shaping is on, the scale moves over 16 samples along either a straight line or a raised-cosine curve. When shaping is off, the scale jumps straight between zero and full.

A symbol lasts four sample-clock pulses. With automatic alignment selected, raising the transmit enable re-phases the symbol timer so that the first word goes out on the very next sample pulse. A path-active flag stays high until any ramp down that is still running has reached zero. Software uses this flag to know when the enable may be dropped safely.

Top module: `tx_ramp_ctrl`

## Requirements
- R1: A transmit word is laid out with bit 7 as the amplitude-request flag and bits 2:0 as the symbol. `fifo_pop` is high for one clock only on a sample-pulse edge that is a symbol boundary while `tx_en` is high and the FIFO is not empty, so exactly one word is taken per four sample pulses.
- R2: With bypass low, the index is (previous index + symbol) mod 8. The running phase is cleared to 0 when `tx_en` rises, so the first index after an enable equals the first symbol.
- R3: With `bypass_mod` high, the index equals bits 2:0 of the popped word, and the running phase is neither used nor changed.
- R4: With `auto_adj` high, the first sample pulse after `tx_en` rises is a symbol boundary, and every fourth pulse after that is one too.
- R5: With `auto_adj` low, boundaries fall on sample pulses 4, 8, 12 … counted from reset, whatever the moment of enabling.
- R6: With `ramp_on` and `ramp_lin` high, each sample pulse moves a ramp position (0..16) one step toward the request. The amplitude is 64 × position, or 1023 at position 16.
- R7: With `ramp_on` high and `ramp_lin` low, the amplitude follows round(1023·(1−cos(π·p/16))/2) for ramp position p.
- R8: With `ramp_on` low, the amplitude is 1023 when the request is high and 0 when it is low. It takes that value on the same sample pulse that pops the word.
- R9: At a boundary with `tx_en` high and the FIFO empty, `underflow` and `sym_vld` are high for that sample period, the previous index is repeated, and no word is popped.
- R10: When `tx_en` is low the request counts as low. `path_active` is high while `tx_en` is high or the amplitude is not zero, so it falls only after a ramp down has finished.
- R11: `sym_idx`, `sym_vld`, `amp`, `path_active` and `underflow` change only on clock edges where `samp_en` is high. `sym_vld` and `underflow` last one sample period.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | One-clock sample pulse |
| tx_en | input | 1 | Transmit path enable |
| auto_adj | input | 1 | Re-phase symbol timer on enable |
| bypass_mod | input | 1 | Use symbol field as absolute index |
| ramp_on | input | 1 | Shaped ramp enable |
| ramp_lin | input | 1 | 1 = linear, 0 = raised-cosine |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | 8 | Word at FIFO head (first-word fall-through) |
| fifo_pop | output | 1 | Take head word |
| sym_idx | output | 3 | Constellation index |
| sym_vld | output | 1 | Index issued this sample period |
| amp | output | 10 | Amplitude scale |
| path_active | output | 1 | Transmit path busy |
| underflow | output | 1 | Boundary found FIFO empty |

## Verification
The assertions assume three things about the inputs: `samp_en` is a single-clock pulse, `fifo_data` holds the head word whenever `fifo_empty` is low, and mode inputs change only while the path is idle or between sample pulses. The bench keeps to all three. It generates the sample pulse every third clock from a counter. It models the FIFO as an array that is read at its head. It changes mode and enable only at falling clock edges, and only between runs of a sequence. It changes the enable alone inside a run, when it drops the path.

// File: rtl/tx_ramp_pkg.sv
package tx_ramp_pkg;
  localparam int AMP_W    = 10;
  localparam int RAMP_LEN = 16;
  localparam int RAMP_LOG = $clog2(RAMP_LEN);
  localparam int SYM_W    = 3;
  localparam logic [AMP_W-1:0] AMP_FULL = '1;

  // raised-cosine shape, entry k = round(1023*(1-cos(pi*k/16))/2)
  function automatic logic [AMP_W-1:0] rc_lookup(input logic [RAMP_LOG-1:0] k);
    case (k)
      4'd0:    return 10'd0;
      4'd1:    return 10'd10;
      4'd2:    return 10'd39;
      4'd3:    return 10'd86;
      4'd4:    return 10'd150;
      4'd5:    return 10'd227;
      4'd6:    return 10'd316;
      4'd7:    return 10'd412;
      4'd8:    return 10'd512;
      4'd9:    return 10'd611;
      4'd10:   return 10'd707;
      4'd11:   return 10'd796;
      4'd12:   return 10'd873;
      4'd13:   return 10'd937;
      4'd14:   return 10'd984;
      default: return 10'd1013;
    endcase
  endfunction
endpackage

// File: rtl/tx_sym_timer.sv
module tx_sym_timer #(
  parameter int SPS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic tx_en,
  input  logic auto_adj,
  output logic sym_tick,
  output logic en_rise
);
  localparam int CNT_W = (SPS > 1) ? $clog2(SPS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SPS - 1);

  logic             en_d;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             force_start;

  assign en_rise     = tx_en & ~en_d;
  assign force_start = auto_adj & (pend_q | en_rise);
  assign sym_tick    = samp_en & (force_start | (cnt_q == CNT_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_d <= tx_en;
      if (samp_en)      pend_q <= 1'b0;
      else if (en_rise) pend_q <= 1'b1;
      if (samp_en)
        cnt_q <= (force_start || cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_sym_mapper.sv
module tx_sym_mapper import tx_ramp_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             samp_en,
  input  logic             take,
  input  logic             en_rise,
  input  logic             bypass_mod,
  input  logic             fifo_empty,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] sym_idx,
  output logic             sym_vld,
  output logic             underflow
);
  logic [SYM_W-1:0] acc_q, acc_base, acc_nxt;
  logic             got_word;

  assign got_word = take & ~fifo_empty;
  assign acc_base = en_rise ? '0 : acc_q;

  always_comb begin
    acc_nxt = acc_base;
    if (got_word && !bypass_mod) acc_nxt = acc_base + sym_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      sym_idx   <= '0;
      sym_vld   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      if (samp_en) begin
        sym_vld   <= take;
        underflow <= take & fifo_empty;
        if (got_word) sym_idx <= bypass_mod ? sym_in : acc_nxt;
      end
    end
  end
endmodule

// File: rtl/tx_amp_ramp.sv
module tx_amp_ramp import tx_ramp_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             samp_en,
  input  logic             load,
  input  logic             flag_in,
  input  logic             tx_en,
  input  logic             ramp_on,
  input  logic             ramp_lin,
  output logic [AMP_W-1:0] amp,
  output logic             path_active
);
  localparam int PW = $clog2(RAMP_LEN + 1);
  localparam logic [PW-1:0] POS_TOP = PW'(RAMP_LEN);

  logic             target_q, tgt_eff;
  logic [PW-1:0]    pos_q, pos_nxt;
  logic [AMP_W-1:0] amp_nxt;

  always_comb begin
    tgt_eff = tx_en & (load ? flag_in : target_q);
    if (!ramp_on)                       pos_nxt = tgt_eff ? POS_TOP : '0;
    else if (tgt_eff && pos_q != POS_TOP) pos_nxt = pos_q + 1'b1;
    else if (!tgt_eff && pos_q != '0)    pos_nxt = pos_q - 1'b1;
    else                                pos_nxt = pos_q;

    if (pos_nxt == POS_TOP) amp_nxt = AMP_FULL;
    else if (ramp_lin)      amp_nxt = AMP_W'(pos_nxt) << (AMP_W - RAMP_LOG);
    else                    amp_nxt = rc_lookup(pos_nxt[RAMP_LOG-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q    <= 1'b0;
      pos_q       <= '0;
      amp         <= '0;
      path_active <= 1'b0;
    end else if (samp_en) begin
      if (load) target_q <= flag_in;
      pos_q       <= pos_nxt;
      amp         <= amp_nxt;
      path_active <= tx_en | (pos_nxt != '0);
    end
  end
endmodule

// File: rtl/tx_ramp_ctrl.sv
module tx_ramp_ctrl import tx_ramp_pkg::*; #(
  parameter int WORD_W = 8,
  parameter int SPS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_en,
  input  logic              tx_en,
  input  logic              auto_adj,
  input  logic              bypass_mod,
  input  logic              ramp_on,
  input  logic              ramp_lin,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [SYM_W-1:0]  sym_idx,
  output logic              sym_vld,
  output logic [AMP_W-1:0]  amp,
  output logic              path_active,
  output logic              underflow
);
  logic sym_tick, en_rise, take;

  assign take     = sym_tick & tx_en;
  assign fifo_pop = take & ~fifo_empty;

  tx_sym_timer #(.SPS(SPS)) u_timer (
    .clk(clk), .rst(rst), .samp_en(samp_en), .tx_en(tx_en),
    .auto_adj(auto_adj), .sym_tick(sym_tick), .en_rise(en_rise)
  );

  tx_sym_mapper u_map (
    .clk(clk), .rst(rst), .samp_en(samp_en), .take(take), .en_rise(en_rise),
    .bypass_mod(bypass_mod), .fifo_empty(fifo_empty),
    .sym_in(fifo_data[SYM_W-1:0]), .sym_idx(sym_idx), .sym_vld(sym_vld),
    .underflow(underflow)
  );

  tx_amp_ramp u_ramp (
    .clk(clk), .rst(rst), .samp_en(samp_en), .load(fifo_pop),
    .flag_in(fifo_data[WORD_W-1]), .tx_en(tx_en), .ramp_on(ramp_on),
    .ramp_lin(ramp_lin), .amp(amp), .path_active(path_active)
  );
endmodule

// File: rtl/tx_ramp_ctrl_chk.sv
module tx_ramp_ctrl_chk import tx_ramp_pkg::*; #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              samp_en,
  input logic              tx_en,
  input logic              auto_adj,
  input logic              ramp_on,
  input logic              ramp_lin,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic [SYM_W-1:0]  sym_idx,
  input logic              sym_vld,
  input logic [AMP_W-1:0]  amp,
  input logic              path_active,
  input logic              underflow
);
  localparam int SH = AMP_W - RAMP_LOG;

  a_r1_pop_guard: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (samp_en && tx_en && !fifo_empty));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> ($stable(amp) && $stable(sym_idx) && $stable(sym_vld)
                  && $stable(path_active) && $stable(underflow)));

  a_r10_busy_while_amp: assert property (@(posedge clk) disable iff (rst)
    (amp != '0) |-> path_active);

  a_r9_uflow_is_slot: assert property (@(posedge clk) disable iff (rst)
    underflow |-> sym_vld);

  a_r8_direct_levels: assert property (@(posedge clk) disable iff (rst)
    (samp_en && !ramp_on) |=> (amp == '0 || amp == AMP_FULL));

  a_r6_linear_grid: assert property (@(posedge clk) disable iff (rst)
    (samp_en && ramp_on && ramp_lin) |=> (amp[SH-1:0] == '0 || amp == AMP_FULL));

  a_r4_auto_first: assert property (@(posedge clk) disable iff (rst)
    (samp_en && auto_adj && !fifo_empty && $rose(tx_en)) |-> fifo_pop);
endmodule

bind tx_ramp_ctrl tx_ramp_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .samp_en(samp_en), .tx_en(tx_en), .auto_adj(auto_adj),
  .ramp_on(ramp_on), .ramp_lin(ramp_lin), .fifo_empty(fifo_empty),
  .fifo_pop(fifo_pop), .sym_idx(sym_idx), .sym_vld(sym_vld), .amp(amp),
  .path_active(path_active), .underflow(underflow)
);

// File: tb/tb_tx_ramp_ctrl.sv
module tb_tx_ramp_ctrl;
  logic clk = 1'b0, rst = 1'b1, samp_en = 1'b0, tx_en = 1'b0;
  logic auto_adj = 1'b0, bypass_mod = 1'b0, ramp_on = 1'b0, ramp_lin = 1'b0;
  logic       fifo_empty, fifo_pop, sym_vld, path_active, underflow;
  logic [7:0] fifo_data;
  logic [2:0] sym_idx;
  logic [9:0] amp;
  logic [7:0] fmem [64];
  int wr = 0, rd, nsamp, sdiv;
  int total = 0, bad = 0;
  int mrd, m_pos, m_acc, m_idx;
  bit m_tgt;

  always #2 clk = ~clk;

  tx_ramp_ctrl dut (
    .clk(clk), .rst(rst), .samp_en(samp_en), .tx_en(tx_en), .auto_adj(auto_adj),
    .bypass_mod(bypass_mod), .ramp_on(ramp_on), .ramp_lin(ramp_lin),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .sym_idx(sym_idx), .sym_vld(sym_vld), .amp(amp),
    .path_active(path_active), .underflow(underflow)
  );

  assign fifo_empty = (rd == wr);
  assign fifo_data  = fmem[rd[5:0]];

  always @(posedge clk) begin
    if (rst) begin
      rd <= 0; nsamp <= 0; sdiv <= 0; samp_en <= 1'b0;
    end else begin
      if (fifo_pop) rd <= rd + 1;
      if (samp_en) nsamp <= nsamp + 1;
      sdiv    <= (sdiv == 2) ? 0 : sdiv + 1;
      samp_en <= (sdiv == 2);
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(string req, int act, int exp);
    total++;
    if (act > exp + 1 || act < exp - 1) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the next sample-pulse edge
  task automatic tick();
    while (!samp_en) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx_en = 1'b0; wr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mrd = 0; m_pos = 0; m_acc = 0; m_idx = 0; m_tgt = 1'b0;
  endtask

  task automatic push(bit flag, int sym);
    fmem[wr[5:0]] = {flag, 4'b0, 3'(sym)};
    wr++;
  endtask

  task automatic enable();
    tx_en = 1'b1;
    m_acc = 0;
  endtask

  function automatic int shape(int p);
    real v;
    v = 1023.0 * (1.0 - $cos(3.141592653589793 * p / 16.0)) / 2.0;
    return $rtoi(v + 0.5);
  endfunction

  task automatic run_seq(int n, bit aut, int drop_at);
    for (int t = 0; t < n; t++) begin
      bit bnd, ev, eu, tg;
      logic [7:0] w;
      int ea;
      if (t == drop_at) tx_en = 1'b0;
      tick();
      bnd = aut ? (t % 4 == 0) : ((nsamp - 1) % 4 == 3);
      ev = 1'b0; eu = 1'b0;
      if (bnd && tx_en) begin
        ev = 1'b1;
        if (mrd < wr) begin
          w = fmem[mrd[5:0]]; mrd++;
          m_tgt = w[7];
          if (bypass_mod) m_idx = int'(w[2:0]);
          else begin m_acc = (m_acc + int'(w[2:0])) % 8; m_idx = m_acc; end
        end else eu = 1'b1;
      end
      tg = tx_en && m_tgt;
      if (!ramp_on) m_pos = tg ? 16 : 0;
      else if (tg && m_pos < 16) m_pos++;
      else if (!tg && m_pos > 0) m_pos--;
      ea = (m_pos == 16) ? 1023 : (ramp_on && !ramp_lin) ? shape(m_pos) : m_pos * 64;
      chk(aut ? "R4 sym_vld" : "R5 sym_vld", int'(sym_vld), int'(ev));
      chk("R9 underflow", int'(underflow), int'(eu));
      if (ev) chk(bypass_mod ? "R3 index" : "R2 index", int'(sym_idx), m_idx);
      if (!ramp_on)      chk("R8 amp", int'(amp), ea);
      else if (ramp_lin) chk("R6 amp", int'(amp), ea);
      else               chk_near("R7 amp", int'(amp), ea);
      chk("R10 path_active", int'(path_active), int'(tx_en || m_pos != 0));
    end
    chk("R1 pop count", rd, mrd);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 amp", int'(amp), 0);
    chk("R12 path_active", int'(path_active), 0);
    chk("R12 sym_vld", int'(sym_vld), 0);
    chk("R12 underflow", int'(underflow), 0);
    chk("R12 sym_idx", int'(sym_idx), 0);

    // auto start, differential, linear ramp, underflow, drop, re-enable
    auto_adj = 1; bypass_mod = 0; ramp_on = 1; ramp_lin = 1;
    for (int i = 0; i < 8; i++) push(1'b1, (3 * i + 1) % 8);
    @(negedge clk); @(negedge clk);
    enable();
    run_seq(40, 1'b1, -1);
    run_seq(20, 1'b1, 0);
    push(1'b1, 5); push(1'b1, 2);
    @(negedge clk);
    enable();
    run_seq(8, 1'b1, -1);
    run_seq(18, 1'b1, 0);

    // bypass, raised-cosine ramp up and down
    do_reset();
    auto_adj = 1; bypass_mod = 1; ramp_on = 1; ramp_lin = 0;
    for (int i = 0; i < 8; i++) push(1'b1, i);
    push(1'b0, 6); push(1'b0, 3);
    @(negedge clk);
    enable();
    run_seq(60, 1'b1, -1);
    run_seq(4, 1'b1, 0);

    // direct amplitude, alternating request
    do_reset();
    auto_adj = 1; bypass_mod = 0; ramp_on = 0; ramp_lin = 0;
    for (int i = 0; i < 10; i++) push(i % 2 == 0, 7 - i % 8);
    @(negedge clk);
    enable();
    run_seq(44, 1'b1, -1);
    run_seq(4, 1'b1, 0);

    // free-running symbol phase, enable at odd moments
    for (int k = 0; k < 3; k++) begin
      do_reset();
      auto_adj = 0; bypass_mod = 0; ramp_on = 1; ramp_lin = 1;
      for (int i = 0; i < 6; i++) push(1'b1, i + k);
      repeat (5 + 4 * k) @(negedge clk);
      enable();
      run_seq(30, 1'b0, -1);
      run_seq(18, 1'b0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule